// File: doc/BRIEF.md
# Enhanced Control Bit Write Lock

This block guards the upper, enhanced fields of four UART control registers: interrupt enable, interrupt status, FIFO control and modem control. A single unlock input decides whether host writes may alter those fields. While the unlock is low, a write still updates the ordinary legacy bits of the addressed register, but the guarded bits keep whatever they last held. Driver code that knows only the legacy register set therefore cannot disturb enhanced settings once they have been programmed and sealed.

The unlock input is registered inside the block. A write is judged by the registered value, which is the unlock level seen at the previous clock edge. Software can seal its settings by programming the fields with the unlock high and then dropping it. It can reopen the lock by raising the unlock again. A read port returns every stored bit, including bits that are currently sealed.

Top module: `enh_ctrl_lock`

## Requirements
- R1: After reset all four registers read 0x00 and `open_o` is 0.
- R2: When `open_o` is 1, a write to index 0 (interrupt enable), 1 (interrupt status), 2 (FIFO control) or 3 (modem control) stores all eight data bits at the next edge.
- R3: When `open_o` is 0, a write leaves the guarded bits unchanged. These are bits 7:4 of index 0, bits 5:4 of index 1, bits 5:4 of index 2 and bits 7:5 of index 3.
- R4: The unguarded bits of the addressed register take the written data at the next edge, whatever `open_o` holds.
- R5: `open_o` equals the value `lock_en_i` had at the previous clock edge.
- R6: A write in the same cycle that `lock_en_i` changes is judged by the old registered value, not by the new input level.
- R7: After guarded bits are written while open and `lock_en_i` is then dropped, later writes keep those guarded values.
- R8: `rd_data_o` returns the stored value of the register selected by `rd_addr_i` (indices 0 to 3), and returns 0x00 for any other index.
- R9: A write to an index outside 0 to 3 changes none of the four registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lock_en_i | input | 1 | Unlock request for guarded fields, registered each cycle |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 3 | Register index for the write |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Register index for readback |
| rd_data_o | output | 8 | Readback of the selected register |
| irq_en_o | output | 8 | Stored interrupt-enable register |
| irq_stat_o | output | 8 | Stored interrupt-status register |
| fifo_ctl_o | output | 8 | Stored FIFO-control register |
| modem_ctl_o | output | 8 | Stored modem-control register |
| open_o | output | 1 | Registered unlock state that governs writes |

## Verification
A change of the unlock input and a host write can fall into the same clock cycle. The bench provokes this by driving `lock_en_i` high, and later low, in the very cycle that a register is written. It then judges the result by the previous registered unlock level: a write issued as the lock is being raised still keeps the guarded bits, and a write issued as the lock is being dropped still takes them. It reads the register back one cycle later and compares it with the value the requirements predict from that prior level.

// File: rtl/enh_lock_pkg.sv
package enh_lock_pkg;

  localparam int unsigned DATA_W   = 8;
  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned ADDR_W   = 3;

  // Guarded-bit masks, one per register index.
  localparam logic [DATA_W-1:0] MASK_IRQ_EN    = 8'hF0;
  localparam logic [DATA_W-1:0] MASK_IRQ_STAT  = 8'h30;
  localparam logic [DATA_W-1:0] MASK_FIFO_CTL  = 8'h30;
  localparam logic [DATA_W-1:0] MASK_MODEM_CTL = 8'hE0;

  typedef logic [DATA_W-1:0] byte_t;
  typedef byte_t [NUM_REGS-1:0] reg_bank_t;

  // Next stored value: guarded bits take new data only when permitted.
  function automatic byte_t guarded_merge(
    input byte_t old_v,
    input byte_t new_v,
    input byte_t mask,
    input logic  permit
  );
    byte_t keep;
    keep = permit ? '0 : mask;
    return (old_v & keep) | (new_v & ~keep);
  endfunction

endpackage

// File: rtl/enh_lock_gate.sv
module enh_lock_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en_in,
  output logic open_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= en_in;
  end

endmodule

// File: rtl/enh_lock_field.sv
module enh_lock_field
  import enh_lock_pkg::*;
#(
  parameter int unsigned IDX   = 0,
  parameter byte_t       GUARD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  byte_t             wr_data,
  input  logic              permit,
  output logic              hit,
  output byte_t             q
);

  assign hit = wr_en && (wr_addr == ADDR_W'(IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (hit) q <= guarded_merge(q, wr_data, GUARD, permit);
  end

endmodule

// File: rtl/enh_lock_rdmux.sv
module enh_lock_rdmux
  import enh_lock_pkg::*;
(
  input  logic [ADDR_W-1:0] rd_addr,
  input  reg_bank_t         bank,
  output byte_t             rd_data
);

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < int'(NUM_REGS); i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = bank[i];
    end
  end

endmodule

// File: rtl/enh_ctrl_lock.sv
module enh_ctrl_lock
  import enh_lock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] irq_en_o,
  output logic [DATA_W-1:0] irq_stat_o,
  output logic [DATA_W-1:0] fifo_ctl_o,
  output logic [DATA_W-1:0] modem_ctl_o,
  output logic              open_o
);

  localparam reg_bank_t GUARDS = '{MASK_MODEM_CTL, MASK_FIFO_CTL,
                                   MASK_IRQ_STAT, MASK_IRQ_EN};

  logic                open_q;
  reg_bank_t           bank_q;
  logic [NUM_REGS-1:0] hit_w;
  reg_bank_t           guarded_view_w;  // guarded bits only, for checking

  enh_lock_gate u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_in  (lock_en_i),
    .open_q (open_q)
  );

  for (genvar g = 0; g < int'(NUM_REGS); g++) begin : g_field
    enh_lock_field #(
      .IDX   (g),
      .GUARD (GUARDS[g])
    ) u_field (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en_i),
      .wr_addr (wr_addr_i),
      .wr_data (wr_data_i),
      .permit  (open_q),
      .hit     (hit_w[g]),
      .q       (bank_q[g])
    );
    assign guarded_view_w[g] = bank_q[g] & GUARDS[g];
  end

  enh_lock_rdmux u_rdmux (
    .rd_addr (rd_addr_i),
    .bank    (bank_q),
    .rd_data (rd_data_o)
  );

  assign irq_en_o    = bank_q[0];
  assign irq_stat_o  = bank_q[1];
  assign fifo_ctl_o  = bank_q[2];
  assign modem_ctl_o = bank_q[3];
  assign open_o      = open_q;

endmodule

// File: rtl/enh_ctrl_lock_chk.sv
module enh_ctrl_lock_chk
  import enh_lock_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                lock_en_i,
  input logic                wr_en_i,
  input logic [ADDR_W-1:0]   wr_addr_i,
  input logic [DATA_W-1:0]   wr_data_i,
  input logic [ADDR_W-1:0]   rd_addr_i,
  input logic [DATA_W-1:0]   rd_data_o,
  input logic [DATA_W-1:0]   irq_en_o,
  input logic [DATA_W-1:0]   modem_ctl_o,
  input logic                open_o,
  input logic [NUM_REGS-1:0] hit_w,
  input reg_bank_t           guarded_view_w
);

  assert_open_full_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && open_o && wr_addr_i == 3'd0) |=> irq_en_o == $past(wr_data_i));

  assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !open_o) |=> $stable(guarded_view_w));

  assert_legacy_irq_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == 3'd0) |=> (irq_en_o & ~MASK_IRQ_EN) == ($past(wr_data_i) & ~MASK_IRQ_EN));

  assert_legacy_modem_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == 3'd3) |=> (modem_ctl_o & ~MASK_MODEM_CTL) == ($past(wr_data_i) & ~MASK_MODEM_CTL));

  assert_open_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> open_o == $past(lock_en_i));

  assert_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i == 3'd0) |-> rd_data_o == irq_en_o);

  assert_no_stray_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr_i > 3'd3) |-> hit_w == '0);

endmodule

bind enh_ctrl_lock enh_ctrl_lock_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .lock_en_i      (lock_en_i),
  .wr_en_i        (wr_en_i),
  .wr_addr_i      (wr_addr_i),
  .wr_data_i      (wr_data_i),
  .rd_addr_i      (rd_addr_i),
  .rd_data_o      (rd_data_o),
  .irq_en_o       (irq_en_o),
  .modem_ctl_o    (modem_ctl_o),
  .open_o         (open_o),
  .hit_w          (hit_w),
  .guarded_view_w (guarded_view_w)
);

// File: tb/enh_ctrl_lock_bench.sv
module enh_ctrl_lock_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lock_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data, irq_en, irq_stat, fifo_ctl, modem_ctl;
  logic       open_s;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  enh_ctrl_lock u_enh_ctrl_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .lock_en_i   (lock_en),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data),
    .irq_en_o    (irq_en),
    .irq_stat_o  (irq_stat),
    .fifo_ctl_o  (fifo_ctl),
    .modem_ctl_o (modem_ctl),
    .open_o      (open_s)
  );

  // Vector: {lock_en, addr[2:0]} nibble, data byte, expected readback byte.
  localparam logic [19:0] VEC [11] = '{
    20'h8_FF_0F,  // R6: unlock raised this cycle, still sealed: R4 only
    20'h8_A5_A5,  // R2 open
    20'hB_FF_FF,  // R2 modem
    20'h1_3C_3C,  // R6: unlock dropped this cycle, still open
    20'h2_FF_CF,  // R3/R4 fifo sealed
    20'h0_00_A0,  // R3/R7 irq_en keeps guarded
    20'h3_00_E0,  // R3/R7 modem keeps guarded
    20'h5_FF_00,  // R9/R8 out of range index
    20'h9_00_30,  // R6 sealed while raising
    20'h9_00_00,  // R2 open again
    20'hA_12_12   // R2 fifo
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic we, input logic [2:0] a, input logic [7:0] d);
    lock_en = en; wr_en = we; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq_en", irq_en, 8'h00);
    check("R1 stat", irq_stat, 8'h00);
    check("R1 fifo", fifo_ctl, 8'h00);
    check("R1 modem", modem_ctl, 8'h00);
    check("R1 open", {7'd0, open_s}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 11; i++) begin
      rd_addr = VEC[i][18:16];
      step(VEC[i][19], 1'b1, VEC[i][18:16], VEC[i][15:8]);
      check($sformatf("R2/R3/R4/R6 vector %0d", i), rd_data, VEC[i][7:0]);
    end

    // R9: write to index 7 touches nothing
    step(1'b1, 1'b1, 3'd7, 8'hFF);
    check("R9 irq_en", irq_en, 8'hA0);
    check("R9 stat", irq_stat, 8'h00);
    check("R9 fifo", fifo_ctl, 8'h12);
    check("R9 modem", modem_ctl, 8'hE0);

    // R5: open follows input one edge later
    step(1'b0, 1'b0, 3'd0, 8'h00);
    check("R5 low", {7'd0, open_s}, 8'h00);
    step(1'b1, 1'b0, 3'd0, 8'h00);
    check("R5 high", {7'd0, open_s}, 8'h01);

    // R7: program, seal, overwrite attempt
    step(1'b1, 1'b1, 3'd0, 8'h5A);
    check("R7 programmed", irq_en, 8'h5A);
    step(1'b0, 1'b0, 3'd0, 8'h00);
    step(1'b0, 1'b1, 3'd0, 8'h00);
    check("R7 sealed", irq_en, 8'h50);

    // R8: readback of sealed bits and of an unused index
    rd_addr = 3'd0; #1;
    check("R8 idx0", rd_data, 8'h50);
    rd_addr = 3'd6; #1;
    check("R8 idx6", rd_data, 8'h00);

    // R6: raise unlock with a modem write in the same cycle
    step(1'b1, 1'b1, 3'd3, 8'h00);
    check("R6 modem", modem_ctl, 8'hE0);
    check("R6 open now", {7'd0, open_s}, 8'h01);

    // R1: reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 again irq_en", irq_en, 8'h00);
    check("R1 again modem", modem_ctl, 8'h00);
    check("R1 again open", {7'd0, open_s}, 8'h00);

    done = 1'b1;
    finish_run();
  end

endmodule